// File: doc/BRIEF.md
# Received Frame CRC Statistics Counters

This block sits next to a receive path and counts, for test purposes, the frames that end with a good check sequence and the frames that end with a bad one. The receive logic raises a one-cycle end-of-frame pulse together with a qualifier that says whether the CRC matched. The CRC itself is computed elsewhere.

Each frame advances exactly one of two tallies. The good tally counts in decimal style up to 9,999 and then starts again from zero. The error tally stops at its all-ones value. A sticky "a frame has arrived" flag is also kept.

Software reads the results through a plain strobe-and-select read port. Every value that is read clears itself as part of that read. A frame that ends in the same cycle as a read is never lost.

Top module: `fcs_tally`

## Requirements
- R1: A synchronous active-high reset clears the good tally, the error tally and the arrival flag, so both read words return 0 afterwards.
- R2: An end-of-frame pulse with `frame_ok`=1 adds one to the good tally and leaves the error tally unchanged.
- R3: An end-of-frame pulse with `frame_ok`=0 adds one to the error tally and leaves the good tally unchanged.
- R4: The good tally holds values 0 to GOOD_MAX (default 9999). A good frame arriving when it holds GOOD_MAX sets it to 0, and counting goes on from there.
- R5: The error tally stops at 2^ERR_W-1 (255 by default). Further bad frames leave it there.
- R6: `rd_data` shows a word picked by `rd_sel`, with no delay:
  - `rd_sel`=0 gives bit 15 = arrival flag, bit 14 = 0 and bits 13:0 = good tally.
  - `rd_sel`=1 gives bits 7:0 = error tally, with all higher bits 0.
  - Holding `rd_sel` without `rd_en` changes no state.
- R7: When `rd_en` is high at a clock edge, the selected word is cleared at that edge:
  - `rd_sel`=0 clears the good tally and the arrival flag.
  - `rd_sel`=1 clears the error tally.
  - The word that was not selected is left alone.
- R8: If a frame ends in the same cycle that its tally is read, the read returns the old value and the tally ends at 1. If the arrival flag is read in the same cycle that a frame ends, the flag ends set.
- R9: Any end-of-frame pulse, good or bad, sets the arrival flag. The flag stays set until word 0 is read or reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| frame_ok | input | 1 | CRC outcome of the ending frame: 1 good, 0 bad |
| rd_en | input | 1 | Read strobe; clears the selected word at the clock edge |
| rd_sel | input | 1 | Word select: 0 flag and good tally, 1 error tally |
| rd_data | output | GOOD_W+2 | Selected read word (16 bits by default) |

## Verification
The bench builds the block with its default parameters: a 14-bit good tally that wraps after 9999 and an 8-bit error tally. With these values both limits can be reached by streaming frames. About ten thousand good frames take the tally through its decimal wrap, and a few hundred bad frames drive the error tally into saturation. Both fit easily inside the run. A behavioural model predicts both read words on every cycle, including reads that land in the same cycle as a frame end.

// File: rtl/fcs_tally.sv
module fcs_tally #(
  parameter int GOOD_W   = 14,
  parameter int GOOD_MAX = 9999,
  parameter int ERR_W    = 8,
  localparam int RD_W    = GOOD_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_end,
  input  logic            frame_ok,
  input  logic            rd_en,
  input  logic            rd_sel,
  output logic [RD_W-1:0] rd_data
);
  localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(GOOD_MAX);
  localparam logic [ERR_W-1:0]  ERR_TOP  = '1;

  logic [GOOD_W-1:0] good, good_base, good_nxt;
  logic [ERR_W-1:0]  err, err_base, err_nxt;
  logic              seen;

  wire clr_g = rd_en & ~rd_sel;
  wire clr_e = rd_en & rd_sel;
  wire inc_g = frame_end & frame_ok;
  wire inc_e = frame_end & ~frame_ok;

  assign good_base = clr_g ? '0 : good;
  assign err_base  = clr_e ? '0 : err;

  always_comb begin
    good_nxt = good_base;
    if (inc_g) good_nxt = (good_base == GOOD_TOP) ? '0 : good_base + 1'b1;
  end

  assign err_nxt = (inc_e && err_base != ERR_TOP) ? err_base + 1'b1 : err_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      good <= '0;
      err  <= '0;
      seen <= 1'b0;
    end else begin
      good <= good_nxt;
      err  <= err_nxt;
      seen <= frame_end | (seen & ~clr_g);
    end
  end

  assign rd_data = rd_sel ? RD_W'(err) : {seen, 1'b0, good};

  // R2: good frame steps the good tally by one below the limit
  a_r2_good_step: assert property (@(posedge clk) disable iff (rst)
    (inc_g && !clr_g && good != GOOD_TOP) |=> good == $past(good) + 1'b1);
  // R3: bad frame leaves the good tally alone
  a_r3_good_hold: assert property (@(posedge clk) disable iff (rst)
    (inc_e && !clr_g) |=> $stable(good));
  // R4: decimal wrap of the good tally
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc_g && !clr_g && good == GOOD_TOP) |=> good == '0);
  // R4: good tally never leaves its decimal range
  a_r4_range: assert property (@(posedge clk) disable iff (rst) good <= GOOD_TOP);
  // R5: the error tally stays saturated
  a_r5_err_sat: assert property (@(posedge clk) disable iff (rst)
    (err == ERR_TOP && !clr_e) |=> err == ERR_TOP);
  // R8: a frame coinciding with a clearing read leaves a count of one
  a_r8_no_loss: assert property (@(posedge clk) disable iff (rst)
    (clr_g && inc_g) |=> good == GOOD_W'(1));
  // R9: the arrival flag is sticky until word 0 is read
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (seen && !clr_g) |=> seen);
  // R9: any frame end sets the arrival flag
  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> seen);
endmodule

// File: tb/sim_fcs_tally.sv
module sim_fcs_tally;
  logic clk = 1'b0, rst = 1'b1;
  logic frame_end = 0, frame_ok = 0, rd_en = 0, rd_sel = 0;
  logic [15:0] rd_data;
  int errors = 0, checks = 0;
  int g = 0, e = 0, f = 0;

  always #5 clk = ~clk;

  fcs_tally u0 (.clk(clk), .rst(rst), .frame_end(frame_end), .frame_ok(frame_ok),
                .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data));

  task automatic step(input bit fe, input bit ok, input bit rd, input bit sel, input string tag);
    int exp;
    @(negedge clk);
    frame_end = fe; frame_ok = ok; rd_en = rd; rd_sel = sel;
    #1;
    exp = sel ? e : ((f << 15) | g);
    checks++;
    if (rd_data !== exp[15:0]) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, exp[15:0]);
    end
    if (rd && !sel) begin g = 0; f = 0; end
    if (rd && sel) e = 0;
    if (fe) begin
      f = 1;
      if (ok) g = (g == 9999) ? 0 : g + 1;
      else if (e < 255) e++;
    end
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; frame_end = 0; rd_en = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0; g = 0; e = 0; f = 0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    step(0, 0, 0, 0, "R1 word0 after reset");
    step(0, 0, 0, 1, "R1 word1 after reset");
    step(1, 1, 0, 0, "R2 good frame");
    step(1, 1, 0, 0, "R2 good frame");
    step(0, 0, 0, 1, "R2 err untouched");
    step(1, 0, 0, 1, "R3 bad frame");
    step(0, 0, 0, 0, "R3 good untouched / R9 flag");
    step(0, 0, 0, 1, "R6 word1 layout");
    step(0, 0, 1, 1, "R7 read err");
    step(0, 0, 0, 1, "R7 err cleared");
    step(0, 0, 0, 0, "R7 good kept");
    step(0, 0, 1, 0, "R7 read good+flag");
    step(0, 0, 0, 0, "R7 good+flag cleared");
    step(1, 0, 0, 0, "R9 bad frame sets flag");
    step(0, 0, 0, 0, "R9 flag sticky");
    step(1, 1, 1, 0, "R8 good read with frame");
    step(0, 0, 0, 0, "R8 good ends at 1");
    step(1, 0, 0, 1, "R3 bad");
    step(1, 0, 1, 1, "R8 err read with frame");
    step(0, 0, 0, 1, "R8 err ends at 1");
    step(1, 0, 1, 0, "R8 flag read with bad frame");
    step(0, 0, 0, 0, "R8 flag ends set");
    for (int i = 0; i < 300; i++) step(1, 0, 0, 1, "R5 error saturation");
    step(0, 0, 0, 1, "R5 saturated at 255");
    step(0, 0, 1, 1, "R5 read saturated");
    step(0, 0, 0, 1, "R5 cleared after read");
    step(0, 0, 1, 0, "R7 clear good");
    for (int i = 0; i < 10005; i++) step(1, 1, 0, i[0], "R4 good count toward wrap");
    step(0, 0, 0, 0, "R4 wrapped to 5");
    step(1, 1, 0, 0, "R2 good");
    do_reset();
    step(0, 0, 0, 0, "R1 mid-run reset word0");
    step(0, 0, 0, 1, "R1 mid-run reset word1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule